// File: doc/BRIEF.md
# Serial Controller FIFO Pair with Trigger Interrupts

This block holds the two data FIFOs that sit between a register interface and a serial shift engine. Software writes words to be sent through a transmit window and reads received words through a receive window. The serial side pulls transmit words and pushes received words, one word per strobe. It also signals the end of each transfer. Words are 8 or 16 bits wide, selected by a mode input. Each direction has 32 bytes of storage, so one FIFO holds 32 byte-words or 16 halfword-words.

Both fill levels are reported in bytes. Writing zero to a level register empties that FIFO. A 3-bit trigger field sets a power-of-two receive threshold. Six sticky status flags record events: underrun, overflow, transmit drained, transfer end, transmit at half, and receive threshold reached. Each flag has an enable at the same bit position in the control register, and one interrupt line combines the enabled flags. Software clears a flag by writing a one to it.

Register select codes are: 0 control, 1 status, 2 transmit level, 3 receive level, 4 transmit window, 5 receive window, 6 trigger level. A register read is combinational.

Top module: `sio_fifo_pair`

## Requirements
- R1: Each FIFO holds 32 entries in 8-bit mode (`half_word_mode`=0) and 16 entries in 16-bit mode. A write to the transmit window (select 4) while the transmit FIFO is full is dropped, and the level does not change.
- R2: A read of select 2 (transmit) or select 3 (receive) returns the fill in bytes: the entry count in 8-bit mode, twice the entry count in 16-bit mode.
- R3: Writing zero to select 2 or 3 empties that FIFO in one cycle. Writing a nonzero value there has no effect.
- R4: The trigger register (select 6, bits 2:0) holds n. Status bit 0 sets while the receive fill in bytes is at least 2^n words' worth, but only while control bit 19 is 1.
- R5: The status flags sit at bits 13 (underrun), 12 (overflow), 9 (transmit drained), 8 (transfer end), 4 (transmit half) and 0 (receive trigger). Their enables sit at the same positions of the control register (select 0). Control reads back only those bits and bit 19. `irq` is 1 exactly when some flag and its enable are both 1.
- R6: Writing the status register (select 1) clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R7: Status bit 9 sets when a pull by the serial side empties the transmit FIFO.
- R8: A received word that arrives while the receive FIFO is full sets status bit 12 and is discarded.
- R9: A `sh_tx_take` while the transmit FIFO is empty sets status bit 13, and `tx_word` reads 0 while the transmit FIFO is empty.
- R10: A read of the receive window (select 5) while the receive FIFO is empty returns 0 and leaves the level at 0.
- R11: Status bit 4 sets when the transmit fill falls from above 16 bytes to 16 bytes or fewer.
- R12: A `sh_xfer_end` strobe sets status bit 8.
- R13: Words leave each FIFO in the order they entered. In 8-bit mode, bits 15:8 of a stored word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_word_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive window |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current select |
| sh_tx_take | input | 1 | Shift engine takes the head transmit word |
| tx_word | output | 16 | Head of the transmit FIFO (0 when empty) |
| sh_rx_put | input | 1 | Shift engine delivers a received word |
| sh_rx_word | input | 16 | Received word |
| sh_xfer_end | input | 1 | End-of-transfer strobe |
| irq | output | 1 | Combined interrupt request |

## Verification
An entry count that has drifted shows up in the byte level at the next register read. It also shows up through data order: a wrong pointer yields a word out of sequence, which the scoreboard catches on the very next pull or window read. A flag that sets on the wrong cycle, or does not clear, shows in the status readback one cycle after the event, and in `irq` as soon as its enable is raised. Boundary states are driven to both edges: exactly full, one past full, exactly at the half mark, and exactly at the threshold.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_TXLVL = 3'd2,
    SEL_RXLVL = 3'd3,
    SEL_TXWIN = 3'd4,
    SEL_RXWIN = 3'd5,
    SEL_TRIG  = 3'd6
  } reg_sel_e;

  localparam int B_UNDER  = 13;
  localparam int B_OVER   = 12;
  localparam int B_TXEND  = 9;
  localparam int B_XEND   = 8;
  localparam int B_TXHALF = 4;
  localparam int B_RXTRG  = 0;
  localparam int B_RXTEN  = 19;

  localparam logic [31:0] STAT_MASK = (32'd1 << B_UNDER) | (32'd1 << B_OVER) |
                                      (32'd1 << B_TXEND) | (32'd1 << B_XEND) |
                                      (32'd1 << B_TXHALF) | (32'd1 << B_RXTRG);
  localparam logic [31:0] CTRL_MASK = STAT_MASK | (32'd1 << B_RXTEN);

  // Entry count to bytes: halfword entries count double.
  function automatic logic [15:0] bytes_of(input logic [15:0] entries, input logic wide);
    return wide ? (entries << 1) : entries;
  endfunction

  // Receive threshold in bytes for a log2 word count.
  function automatic logic [15:0] thresh_bytes(input logic [2:0] log2n, input logic wide);
    logic [15:0] words;
    words = 16'd1 << log2n;
    return wide ? (words << 1) : words;
  endfunction

endpackage

// File: rtl/sio_word_fifo.sv
module sio_word_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  input  logic [CW-1:0] cap,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign rdata   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit #(
  parameter int          SW   = 32,
  parameter logic [SW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_evt,
  input  logic          clr_wr,
  input  logic [SW-1:0] clr_mask,
  input  logic [SW-1:0] enable,
  output logic [SW-1:0] status,
  output logic          irq
);

  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (IMPL[i]) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else if (set_evt[i]) flag_q <= 1'b1;
        else if (clr_wr && clr_mask[i]) flag_q <= 1'b0;
      end
      assign status[i] = flag_q;
    end else begin : g_none
      assign status[i] = 1'b0;
    end
  end

  assign irq = |(status & enable);

endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_word_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sh_tx_take,
  output logic [WORD_W-1:0] tx_word,
  input  logic              sh_rx_put,
  input  logic [WORD_W-1:0] sh_rx_word,
  input  logic              sh_xfer_end,
  output logic              irq
);

  localparam int HALF_BYTES = DEPTH / 2;
  localparam int NARROW_W   = WORD_W / 2;

  // Register decode
  logic wr_ctrl, wr_stat, wr_txlvl, wr_rxlvl, wr_txwin, wr_trig, rd_rxwin;
  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_stat  = reg_wr && (reg_sel == SEL_STAT);
  assign wr_txlvl = reg_wr && (reg_sel == SEL_TXLVL);
  assign wr_rxlvl = reg_wr && (reg_sel == SEL_RXLVL);
  assign wr_txwin = reg_wr && (reg_sel == SEL_TXWIN);
  assign wr_trig  = reg_wr && (reg_sel == SEL_TRIG);
  assign rd_rxwin = reg_rd && (reg_sel == SEL_RXWIN);

  logic [31:0] ctrl_q;
  logic [2:0]  trig_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      trig_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
      if (wr_trig) trig_q <= reg_wdata[2:0];
    end
  end

  // Word width handling
  logic [CW-1:0]     cap_entries;
  logic [WORD_W-1:0] tx_in, rx_in;
  assign cap_entries = half_word_mode ? CW'(DEPTH / 2) : CW'(DEPTH);
  assign tx_in = half_word_mode ? reg_wdata[WORD_W-1:0]
                                : {{(WORD_W-NARROW_W){1'b0}}, reg_wdata[NARROW_W-1:0]};
  assign rx_in = half_word_mode ? sh_rx_word
                                : {{(WORD_W-NARROW_W){1'b0}}, sh_rx_word[NARROW_W-1:0]};

  // Named internal events, also observed by the checker
  logic tx_flush, rx_flush, tx_push_req, rx_pop_req;
  logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [WORD_W-1:0] rx_head;

  assign tx_flush    = wr_txlvl && (reg_wdata == '0);
  assign rx_flush    = wr_rxlvl && (reg_wdata == '0);
  assign tx_push_req = wr_txwin;
  assign rx_pop_req  = rd_rxwin;

  sio_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push_req), .wdata(tx_in), .pop(sh_tx_take), .cap(cap_entries),
    .rdata(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  sio_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(sh_rx_put), .wdata(rx_in), .pop(rx_pop_req), .cap(cap_entries),
    .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  // Byte levels
  logic [15:0] tx_lvl_b, rx_lvl_b;
  assign tx_lvl_b = bytes_of(16'(tx_cnt), half_word_mode);
  assign rx_lvl_b = bytes_of(16'(rx_cnt), half_word_mode);

  // Events
  logic unf_evt, ovf_evt, txend_evt, xend_evt, txhalf_evt, rxtrg_evt;
  logic tx_above_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_above_q <= 1'b0;
    else        tx_above_q <= (tx_lvl_b > 16'(HALF_BYTES));
  end

  assign unf_evt    = sh_tx_take && tx_empty;
  assign ovf_evt    = sh_rx_put && rx_full && !rx_flush;
  assign txend_evt  = tx_pop_ok && (tx_cnt == CW'(1)) && !tx_push_ok;
  assign xend_evt   = sh_xfer_end;
  assign txhalf_evt = tx_above_q && (tx_lvl_b <= 16'(HALF_BYTES));
  assign rxtrg_evt  = ctrl_q[B_RXTEN] && !rx_empty &&
                      (rx_lvl_b >= thresh_bytes(trig_q, half_word_mode));

  logic [31:0] set_vec, stat_q;
  always_comb begin
    set_vec           = '0;
    set_vec[B_UNDER]  = unf_evt;
    set_vec[B_OVER]   = ovf_evt;
    set_vec[B_TXEND]  = txend_evt;
    set_vec[B_XEND]   = xend_evt;
    set_vec[B_TXHALF] = txhalf_evt;
    set_vec[B_RXTRG]  = rxtrg_evt;
  end

  logic stat_wr;
  assign stat_wr = wr_stat;

  sio_irq_unit #(.SW(32), .IMPL(STAT_MASK)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(set_vec),
    .clr_wr(stat_wr), .clr_mask(reg_wdata), .enable(ctrl_q & STAT_MASK),
    .status(stat_q), .irq(irq)
  );

  // Read mux
  always_comb begin
    case (reg_sel)
      SEL_CTRL:  reg_rdata = ctrl_q;
      SEL_STAT:  reg_rdata = stat_q;
      SEL_TXLVL: reg_rdata = {16'b0, tx_lvl_b};
      SEL_RXLVL: reg_rdata = {16'b0, rx_lvl_b};
      SEL_RXWIN: reg_rdata = 32'(rx_head);
      SEL_TRIG:  reg_rdata = {29'b0, trig_q};
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sio_fifo_pair_chk.sv
module sio_fifo_pair_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_full,
  input logic          tx_push_req,
  input logic          tx_pop_ok,
  input logic          tx_push_ok,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          rx_pop_req,
  input logic          sh_rx_put,
  input logic          sh_xfer_end,
  input logic          ovf_evt,
  input logic          unf_evt,
  input logic          stat_wr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   stat_q
);

  assert_tx_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_req && tx_full && !tx_pop_ok && !tx_flush) |=> (tx_cnt == $past(tx_cnt)));

  assert_rx_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0));

  assert_tx_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[12] && !ovf_evt) |=> !stat_q[12]);

  assert_txend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_ok && tx_cnt == CW'(1) && !tx_push_ok) |=> stat_q[9]);

  assert_no_overflow_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !rx_pop_req) |=> (rx_cnt == $past(rx_cnt) && stat_q[12]));

  assert_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> stat_q[13]);

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_req && rx_cnt == '0 && !sh_rx_put) |=> (rx_cnt == '0));

  assert_xfer_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sh_xfer_end |=> stat_q[8]);

endmodule

bind sio_fifo_pair sio_fifo_pair_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_full(tx_full), .tx_push_req(tx_push_req), .tx_pop_ok(tx_pop_ok),
  .tx_push_ok(tx_push_ok), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .rx_pop_req(rx_pop_req), .sh_rx_put(sh_rx_put), .sh_xfer_end(sh_xfer_end),
  .ovf_evt(ovf_evt), .unf_evt(unf_evt), .stat_wr(stat_wr),
  .reg_wdata(reg_wdata), .stat_q(stat_q)
);

// File: tb/sio_fifo_pair_tb.sv
`timescale 1ns/1ps
module sio_fifo_pair_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_word_mode = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sh_tx_take = 1'b0;
  logic [15:0] tx_word;
  logic        sh_rx_put = 1'b0;
  logic [15:0] sh_rx_word = '0;
  logic        sh_xfer_end = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] tx_q[$];
  logic [15:0] rx_q[$];
  int tx_model = 0;
  int rx_model = 0;

  always #2 clk = ~clk;

  sio_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n), .half_word_mode(half_word_mode),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sh_tx_take(sh_tx_take), .tx_word(tx_word),
    .sh_rx_put(sh_rx_put), .sh_rx_word(sh_rx_word), .sh_xfer_end(sh_xfer_end),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-PAIR FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_peek(input logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] mask_w(input logic [15:0] d);
    return half_word_mode ? d : {8'h00, d[7:0]};
  endfunction

  function automatic int cap();
    return half_word_mode ? 16 : 32;
  endfunction

  // Driver: transmit window write, expectation enters the scoreboard
  task automatic tx_push(input logic [15:0] d);
    if (tx_model < cap()) begin
      tx_q.push_back(mask_w(d));
      tx_model++;
    end
    reg_write(3'd4, 32'(d));
  endtask

  // Monitor: pull one word from the serial side and compare with the scoreboard
  task automatic tx_pull_cmp(input string req);
    logic [15:0] got;
    @(negedge clk);
    #1 got = tx_word;
    sh_tx_take = 1'b1;
    @(negedge clk);
    sh_tx_take = 1'b0;
    if (tx_q.size() > 0) begin
      check(req, 32'(got), 32'(tx_q.pop_front()));
      tx_model--;
    end else begin
      check(req, 32'(got), 32'h0);
    end
  endtask

  task automatic rx_put(input logic [15:0] d);
    if (rx_model < cap()) begin
      rx_q.push_back(mask_w(d));
      rx_model++;
    end
    @(negedge clk);
    sh_rx_word = d; sh_rx_put = 1'b1;
    @(negedge clk);
    sh_rx_put = 1'b0;
  endtask

  task automatic rx_read_cmp(input string req);
    logic [15:0] exp;
    logic [31:0] got;
    @(negedge clk);
    reg_sel = 3'd5;
    #1 got = reg_rdata;
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    exp = (rx_q.size() > 0) ? rx_q.pop_front() : 16'h0;
    if (rx_model > 0) rx_model--;
    check(req, got, 32'(exp));
  endtask

  task automatic flush_all();
    reg_write(3'd2, 32'h0);
    reg_write(3'd3, 32'h0);
    tx_q.delete(); rx_q.delete();
    tx_model = 0; rx_model = 0;
    reg_write(3'd1, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FIFO-PAIR FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // Reset state
    reg_peek(3'd2, v); check("R2 reset tx level", v, 32'h0);
    reg_peek(3'd3, v); check("R2 reset rx level", v, 32'h0);
    reg_peek(3'd1, v); check("R5 reset status", v, 32'h0);
    check("R5 reset irq", 32'(irq), 32'h0);

    // Byte mode order, masking, drain
    tx_push(16'h01A5); tx_push(16'h02B6); tx_push(16'h03C7);
    reg_peek(3'd2, v); check("R2 tx level three bytes", v, 32'd3);
    for (int i = 0; i < 3; i++) tx_pull_cmp("R13 tx order and byte mask");
    idle();
    reg_peek(3'd1, v); check("R7 tx drained flag", v & 32'h200, 32'h200);
    check("R11 no half flag below half", v & 32'h10, 32'h0);
    reg_write(3'd1, 32'hFFFF_FFFF);

    // Underrun
    tx_pull_cmp("R9 empty tx word is zero");
    idle();
    reg_peek(3'd1, v); check("R9 underrun flag", v & 32'h2000, 32'h2000);

    // Transfer end and write-one-to-clear
    @(negedge clk); sh_xfer_end = 1'b1; @(negedge clk); sh_xfer_end = 1'b0;
    reg_peek(3'd1, v); check("R12 transfer end flag", v & 32'h100, 32'h100);
    reg_write(3'd1, 32'h0);
    reg_peek(3'd1, v); check("R6 zero write keeps flags", v, 32'h2100);
    reg_write(3'd1, 32'h2000);
    reg_peek(3'd1, v); check("R6 one clears only its flag", v, 32'h0100);

    // Interrupt combining and control readback
    reg_write(3'd0, 32'h100);
    check("R5 irq with enabled flag", 32'(irq), 32'h1);
    reg_write(3'd0, 32'h2000);
    check("R5 irq with disabled flag", 32'(irq), 32'h0);
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_peek(3'd0, v); check("R5 control readback mask", v, 32'h0008_3311);
    reg_write(3'd0, 32'h0);
    flush_all();

    // Overflow in byte mode
    for (int i = 0; i < 33; i++) rx_put(16'(i * 7 + 16'h0300));
    reg_peek(3'd3, v); check("R1 rx level capped", v, 32'd32);
    idle();
    reg_peek(3'd1, v); check("R8 overflow flag", v & 32'h1000, 32'h1000);
    for (int i = 0; i < 32; i++) rx_read_cmp("R8 rx order, extra word discarded");
    rx_read_cmp("R10 empty read returns zero");
    reg_peek(3'd3, v); check("R10 level stays zero", v, 32'h0);
    flush_all();

    // Receive trigger, byte mode, n=2
    reg_write(3'd6, 32'd2);
    for (int i = 0; i < 4; i++) rx_put(16'(i + 1));
    idle();
    reg_peek(3'd1, v); check("R4 trigger gated by enable", v & 32'h1, 32'h0);
    reg_write(3'd0, 32'h0008_0000);
    idle();
    reg_peek(3'd1, v); check("R4 trigger at threshold", v & 32'h1, 32'h1);
    reg_write(3'd3, 32'd9);
    reg_peek(3'd3, v); check("R3 nonzero level write ignored", v, 32'd4);
    reg_write(3'd3, 32'h0);
    reg_peek(3'd3, v); check("R3 zero write flushes rx", v, 32'h0);
    rx_q.delete(); rx_model = 0;
    reg_write(3'd1, 32'hFFFF_FFFF);
    idle();
    reg_peek(3'd1, v); check("R4 no trigger when empty", v & 32'h1, 32'h0);

    // Halfword mode, n=1 means 2 words = 4 bytes
    half_word_mode = 1'b1;
    reg_write(3'd6, 32'd1);
    rx_put(16'hBEEF);
    idle();
    reg_peek(3'd3, v); check("R2 halfword level in bytes", v, 32'd2);
    reg_peek(3'd1, v); check("R4 below halfword threshold", v & 32'h1, 32'h0);
    rx_put(16'h1234);
    idle();
    reg_peek(3'd1, v); check("R4 halfword threshold reached", v & 32'h1, 32'h1);
    rx_read_cmp("R13 halfword rx order");
    rx_read_cmp("R13 halfword rx order");
    reg_write(3'd0, 32'h0);
    flush_all();
    for (int i = 0; i < 17; i++) rx_put(16'(16'hA000 + i));
    reg_peek(3'd3, v); check("R1 halfword capacity 16 entries", v, 32'd32);
    idle();
    reg_peek(3'd1, v); check("R8 halfword overflow", v & 32'h1000, 32'h1000);
    flush_all();
    half_word_mode = 1'b0;
    flush_all();

    // Transmit full drop and half mark
    for (int i = 0; i < 33; i++) tx_push(16'(i + 16'h40));
    reg_peek(3'd2, v); check("R1 tx write when full dropped", v, 32'd32);
    for (int i = 0; i < 15; i++) tx_pull_cmp("R13 tx order");
    idle();
    reg_peek(3'd1, v); check("R11 no half flag at 17 bytes", v & 32'h10, 32'h0);
    tx_pull_cmp("R13 tx order");
    idle();
    reg_peek(3'd1, v); check("R11 half flag at 16 bytes", v & 32'h10, 32'h10);
    for (int i = 0; i < 16; i++) tx_pull_cmp("R1 tx order after drop");
    reg_peek(3'd2, v); check("R1 tx empty after 32 pulls", v, 32'h0);
    reg_write(3'd2, 32'h0);
    reg_peek(3'd2, v); check("R3 tx flush on empty", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule